// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of a synchronous DRAM burst. A one-cycle start pulse carries the first column, a burst-length code and an ordering bit. From the next cycle on, the block presents one column per clock together with a beat-valid flag. It marks the final beat of a fixed-length burst. The caller places the column on the memory's address pins and moves the data. Bank handling and command generation are done elsewhere.

A fixed-length burst stays inside the aligned block of its own length. It follows either a wrapping increment or an exclusive-OR ordering of the beat number. The page-long burst runs through all 512 columns in increasing order and keeps going until a terminate input stops it. This page-long mode is only valid with the incrementing order. Because a random column may be issued on any clock, a start pulse always overrides whatever burst is running. A length or ordering combination that is not allowed is reported by a one-cycle illegal flag and starts nothing.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, and before any start, `beat_vld`, `burst_done` and `illegal` are low and `col_out` is 0.
- R2: `bl_code` selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives a page-long burst. Codes 4, 5 and 6 are reserved. `wrap_il` low selects incrementing order and high selects exclusive-OR order. A fixed burst delivers exactly the selected number of beats.
- R3: A start sampled on a clock edge makes `beat_vld` high with `col_out` equal to `start_col` in the cycle after that edge.
- R4: With incrementing order and a fixed length BL, beat k keeps the bits of `start_col` above the low log2(BL) bits. The low log2(BL) bits are (start + k) mod BL.
- R5: With exclusive-OR order and a fixed length, beat k is `start_col` XOR k.
- R6: `burst_done` is high for exactly one cycle, together with the last beat of a fixed burst. Without a new start, `beat_vld` is low in the following cycle.
- R7: A page-long burst gives consecutive columns, wrapping from 511 to 0. It never raises `burst_done` and continues until terminated.
- R8: When `term` is high at an edge with no start while a burst runs, no beat is presented in the next cycle and the burst ends.
- R9: A start that arrives while a burst runs abandons that burst. The new burst's first beat follows in the next cycle, with no gap.
- R10: A start with a reserved code, or with code 7 together with exclusive-OR order, raises `illegal` for one cycle in place of a first beat. It presents no beat and ends any running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse that begins a new burst |
| start_col | input | 9 | First column of the burst |
| bl_code | input | 3 | Burst length code |
| wrap_il | input | 1 | Ordering select: 0 incrementing, 1 exclusive-OR |
| term | input | 1 | Stops a running burst |
| col_out | output | 9 | Column address of the current beat |
| beat_vld | output | 1 | A beat is presented this cycle |
| burst_done | output | 1 | Current beat is the last beat of a fixed burst |
| illegal | output | 1 | The start just sampled had an invalid configuration |

## Verification
A corrupted beat index or stored base column shows up at `col_out` on the very next beat. The bench compares every cycle, so the error is seen at once. A wrong length mask or a wrong page-long flag moves the end of the burst. This appears as a missing, early or extra `burst_done` within at most eight beats for fixed bursts. For page-long bursts, it appears as a column that fails to step by one. A lost or stuck active flag shows as a beat that appears or vanishes in the cycle after a start, a terminate or a final beat.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int unsigned PAGE_COL_W = 9;
  localparam int unsigned CODE_W     = 3;
  localparam int unsigned MAX_LOG_BL = 3;

  localparam logic [CODE_W-1:0] BLC_1    = 3'd0;
  localparam logic [CODE_W-1:0] BLC_2    = 3'd1;
  localparam logic [CODE_W-1:0] BLC_4    = 3'd2;
  localparam logic [CODE_W-1:0] BLC_8    = 3'd3;
  localparam logic [CODE_W-1:0] BLC_PAGE = 3'd7;

  typedef enum logic {
    ORD_INC = 1'b0,
    ORD_XOR = 1'b1
  } order_e;
endpackage

// File: rtl/bcs_cfg_decode.sv
module bcs_cfg_decode
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = PAGE_COL_W
) (
  input  logic [CODE_W-1:0] code,
  input  order_e            order,
  output logic [COL_W-1:0]  len_mask,
  output logic              page_mode,
  output logic              single,
  output logic              bad_cfg
);
  function automatic logic [COL_W-1:0] mask_of(input int unsigned lg);
    return (COL_W'(1) << lg) - COL_W'(1);
  endfunction

  logic reserved;

  always_comb begin
    len_mask  = '0;
    page_mode = 1'b0;
    reserved  = 1'b0;
    case (code)
      BLC_1:    len_mask = mask_of(0);
      BLC_2:    len_mask = mask_of(1);
      BLC_4:    len_mask = mask_of(2);
      BLC_8:    len_mask = mask_of(MAX_LOG_BL);
      BLC_PAGE: begin
        len_mask  = '1;
        page_mode = 1'b1;
      end
      default:  reserved = 1'b1;
    endcase
  end

  assign bad_cfg = reserved || (page_mode && (order == ORD_XOR));
  assign single  = !bad_cfg && !page_mode && (len_mask == '0);
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = PAGE_COL_W
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  logic [COL_W-1:0] len_mask,
  input  order_e           order,
  output logic [COL_W-1:0] col
);
  function automatic logic [COL_W-1:0] inc_col(input logic [COL_W-1:0] b,
                                                input logic [COL_W-1:0] k,
                                                input logic [COL_W-1:0] m);
    logic [COL_W-1:0] sum;
    sum = b + k;
    return (b & ~m) | (sum & m);
  endfunction

  logic [COL_W-1:0] col_inc;
  logic [COL_W-1:0] col_xor;

  assign col_inc = inc_col(base, idx, len_mask);

  for (genvar b = 0; b < COL_W; b++) begin : g_xor_bit
    assign col_xor[b] = len_mask[b] ? (base[b] ^ idx[b]) : base[b];
  end

  assign col = (order == ORD_XOR) ? col_xor : col_inc;
endmodule

// File: rtl/bcs_beat_ctl.sv
module bcs_beat_ctl
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = PAGE_COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             term,
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] dec_mask,
  input  logic             dec_page,
  input  logic             dec_single,
  input  logic             dec_bad,
  input  order_e           dec_order,
  output logic             launch,
  output logic             advance,
  output logic             last_beat,
  output logic [COL_W-1:0] cur_base,
  output logic [COL_W-1:0] cur_idx,
  output logic [COL_W-1:0] cur_mask,
  output logic             cur_page,
  output order_e           cur_order
);
  logic active_q;

  assign launch    = start && !dec_bad;
  assign advance   = active_q && !start && !term;
  assign last_beat = !cur_page && (cur_idx == cur_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      cur_base  <= '0;
      cur_idx   <= '0;
      cur_mask  <= '0;
      cur_page  <= 1'b0;
      cur_order <= ORD_INC;
    end else if (launch) begin
      active_q  <= !dec_single;
      cur_base  <= start_col;
      cur_idx   <= COL_W'(1);
      cur_mask  <= dec_mask;
      cur_page  <= dec_page;
      cur_order <= dec_order;
    end else if (advance) begin
      cur_idx <= cur_idx + COL_W'(1);
      if (last_beat) active_q <= 1'b0;
    end else if (start || term) begin
      active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = PAGE_COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic [CODE_W-1:0] bl_code,
  input  logic              wrap_il,
  input  logic              term,
  output logic [COL_W-1:0]  col_out,
  output logic              beat_vld,
  output logic              burst_done,
  output logic              illegal
);
  order_e           in_order;
  logic [COL_W-1:0] dec_mask;
  logic             dec_page;
  logic             dec_single;
  logic             dec_bad;

  logic             launch;
  logic             advance;
  logic             last_beat;
  logic [COL_W-1:0] cur_base;
  logic [COL_W-1:0] cur_idx;
  logic [COL_W-1:0] cur_mask;
  logic             cur_page;
  order_e           cur_order;

  logic [COL_W-1:0] sel_base;
  logic [COL_W-1:0] sel_idx;
  logic [COL_W-1:0] sel_mask;
  order_e           sel_order;
  logic [COL_W-1:0] next_col;
  logic             beat_fire;
  logic             done_fire;

  assign in_order = wrap_il ? ORD_XOR : ORD_INC;

  bcs_cfg_decode #(.COL_W(COL_W)) u_dec (
    .code      (bl_code),
    .order     (in_order),
    .len_mask  (dec_mask),
    .page_mode (dec_page),
    .single    (dec_single),
    .bad_cfg   (dec_bad)
  );

  bcs_beat_ctl #(.COL_W(COL_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .term       (term),
    .start_col  (start_col),
    .dec_mask   (dec_mask),
    .dec_page   (dec_page),
    .dec_single (dec_single),
    .dec_bad    (dec_bad),
    .dec_order  (in_order),
    .launch     (launch),
    .advance    (advance),
    .last_beat  (last_beat),
    .cur_base   (cur_base),
    .cur_idx    (cur_idx),
    .cur_mask   (cur_mask),
    .cur_page   (cur_page),
    .cur_order  (cur_order)
  );

  assign sel_base  = launch ? start_col : cur_base;
  assign sel_idx   = launch ? '0        : cur_idx;
  assign sel_mask  = launch ? dec_mask  : cur_mask;
  assign sel_order = launch ? in_order  : cur_order;

  bcs_addr_gen #(.COL_W(COL_W)) u_gen (
    .base     (sel_base),
    .idx      (sel_idx),
    .len_mask (sel_mask),
    .order    (sel_order),
    .col      (next_col)
  );

  assign beat_fire = launch || advance;
  assign done_fire = launch ? dec_single : (advance && last_beat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_out    <= '0;
      beat_vld   <= 1'b0;
      burst_done <= 1'b0;
      illegal    <= 1'b0;
    end else begin
      if (beat_fire) col_out <= next_col;
      beat_vld   <= beat_fire;
      burst_done <= done_fire;
      illegal    <= start && dec_bad;
    end
  end
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int unsigned COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             term,
  input logic [COL_W-1:0] start_col,
  input logic [COL_W-1:0] col_out,
  input logic             beat_vld,
  input logic             burst_done,
  input logic             illegal,
  input logic             launch,
  input logic             advance,
  input logic             cur_page
);
  AST_DONE_WITH_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> beat_vld); // R6
  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done && !start |=> !beat_vld); // R6
  AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !beat_vld && !burst_done); // R10
  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> beat_vld && (col_out == $past(start_col))); // R3
  AST_TERM_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    !start && term |=> !beat_vld); // R8
  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    advance && cur_page |=> col_out == COL_W'($past(col_out) + COL_W'(1))); // R7
  AST_PAGE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    advance && cur_page |=> !burst_done); // R7
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .term       (term),
  .start_col  (start_col),
  .col_out    (col_out),
  .beat_vld   (beat_vld),
  .burst_done (burst_done),
  .illegal    (illegal),
  .launch     (launch),
  .advance    (advance),
  .cur_page   (cur_page)
);

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [8:0] start_col = '0;
  logic [2:0] bl_code = '0;
  logic       wrap_il = 1'b0;
  logic       term = 1'b0;
  logic [8:0] col_out;
  logic       beat_vld;
  logic       burst_done;
  logic       illegal;

  int checks = 0;
  int failures = 0;

  // reference state
  bit    m_act = 0;
  int    m_base, m_len, m_k, m_cnt;
  bit    m_page, m_il;
  bit    e_vld = 0, e_done = 0, e_ill = 0;
  int    e_col = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  burst_col_seq i_burst_col_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .bl_code(bl_code), .wrap_il(wrap_il), .term(term), .col_out(col_out),
    .beat_vld(beat_vld), .burst_done(burst_done), .illegal(illegal)
  );

  function automatic int ref_col(int base, int k, int len, bit il, bit page);
    if (il) return base ^ k;
    if (page) return (base + k) % 512;
    return (base / len) * len + ((base % len) + k) % len;
  endfunction

  task automatic check(string req, bit ok, string act_s, string exp_s);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%s expected=%s", req, act_s, exp_s);
    end
  endtask

  task automatic model_edge();
    bit was_act = m_act;
    e_vld = 0; e_done = 0; e_ill = 0;
    if (start) begin
      int  len = 0;
      bit  page = 0, bad = 0;
      case (bl_code)
        3'd0: len = 1;
        3'd1: len = 2;
        3'd2: len = 4;
        3'd3: len = 8;
        3'd7: begin len = 512; page = 1; end
        default: bad = 1;
      endcase
      if (page && wrap_il) bad = 1;
      if (bad) begin
        e_ill = 1; m_act = 0; tag = "R10";
      end else begin
        m_base = int'(start_col); m_len = len; m_page = page; m_il = wrap_il;
        e_vld = 1; e_col = m_base; m_k = 1; m_cnt = 1;
        e_done = !page && len == 1;
        m_act = !e_done;
        tag = was_act ? "R9" : "R3";
      end
    end else if (m_act) begin
      if (term) begin
        m_act = 0; tag = "R8";
      end else begin
        e_vld = 1;
        e_col = ref_col(m_base, m_k, m_len, m_il, m_page);
        m_cnt++;
        e_done = !m_page && (m_k == m_len - 1);
        m_act = !e_done;
        m_k = (m_k + 1) % 512;
        tag = m_page ? "R7" : (m_il ? "R5" : "R4");
        if (e_done) tag = "R6";
      end
    end else begin
      tag = "R6";
    end
  endtask

  task automatic compare();
    bit ok;
    ok = (beat_vld == e_vld) && (burst_done == e_done) && (illegal == e_ill) &&
         (!e_vld || int'(col_out) == e_col);
    check(tag, ok,
          $sformatf("vld=%0b done=%0b ill=%0b col=%0d", beat_vld, burst_done, illegal, col_out),
          $sformatf("vld=%0b done=%0b ill=%0b col=%0d", e_vld, e_done, e_ill, e_col));
    if (e_done)
      check("R2", m_cnt == m_len, $sformatf("beats=%0d", m_cnt), $sformatf("beats=%0d", m_len));
  endtask

  task automatic cycle();
    @(posedge clk);
    model_edge();
    #1;
    compare();
    @(negedge clk);
    start = 0;
    term = 0;
  endtask

  task automatic kick(int col, int code, bit il);
    start = 1; start_col = 9'(col); bl_code = 3'(code); wrap_il = il;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    #12;
    check("R1", !beat_vld && !burst_done && !illegal && col_out == 0,
          $sformatf("vld=%0b done=%0b ill=%0b col=%0d", beat_vld, burst_done, illegal, col_out),
          "all zero");
    @(negedge clk);
    rst_n = 1;
    cycle();
    check("R1", !beat_vld && col_out == 0, $sformatf("col=%0d", col_out), "col=0 idle");

    // incrementing BL8 from 501: 501,502,503,496..500
    kick(501, 3, 0);
    for (int i = 0; i < 10; i++) cycle();
    // exclusive-OR BL4 from 0x0A6
    kick(166, 2, 1);
    for (int i = 0; i < 6; i++) cycle();
    // single beat
    kick(77, 0, 0);
    for (int i = 0; i < 3; i++) cycle();
    // page-long from 509, wraps to 0, then terminate
    kick(509, 7, 0);
    for (int i = 0; i < 7; i++) cycle();
    term = 1;
    for (int i = 0; i < 3; i++) cycle();
    // illegal: page-long with exclusive-OR, issued during a running burst
    kick(40, 3, 1);
    cycle(); cycle();
    kick(10, 7, 1);
    for (int i = 0; i < 3; i++) cycle();
    // reserved code
    kick(12, 5, 0);
    for (int i = 0; i < 2; i++) cycle();
    // interrupt a burst, then back to back at the final beat
    kick(8, 3, 0);
    cycle(); cycle(); cycle();
    kick(300, 1, 1);
    cycle(); 
    kick(20, 1, 0);
    for (int i = 0; i < 4; i++) cycle();

    for (int n = 0; n < 3000; n++) begin
      if (($urandom % 100) < 9) begin
        kick(int'($urandom % 512), int'($urandom % 8), 1'($urandom % 2));
      end
      term = (($urandom % 40) == 0);
      cycle();
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule